// File: doc/BRIEF.md
# Write-Only Multi-Device Serial Register Writer

This block is a serial-bus master that writes registers in a group of converter devices sharing one clock and data line. Each device has its own active-low chip select. The user side offers an 8-bit device number, an 8-bit register address, 16-bit write data and a one-cycle start strobe. An idle output tells the caller when a new write may be issued. The block cannot read from a device and has no read-data path.

Each transaction sends one frame. The frame opens with a 16-bit instruction word and then carries two data bytes, most significant bit first. The target device only applies staged writes after bit 0 of its update register at address 0xFF is written. When the auto-commit input is set, the block therefore follows the data frame with a second frame that writes 0x01 to that address. It raises idle only after both frames. The serial clock comes from a programmable half-period divider of the 40 MHz system clock. Data changes on the falling serial-clock edge, so the device can sample it on the rising edge.

Top module: `spi_wr_engine`

## Requirements
- R1: `idle_o` is high exactly when no frame or inter-frame gap is in progress. A strobe on `wr_i` during an idle cycle is accepted at that clock edge, and `idle_o` is low from the next cycle until the transaction ends.
- R2: During a frame, only the chip select of the latched device number is low. The device number is taken from `dev_sel_i` at acceptance. A device number of NUM_DEV or more asserts no chip select, but the frame still runs on the clock and data lines. A chip select stays low without a break for its whole frame.
- R3: The data frame is 32 bits, sent MSB first, and its 16-bit instruction word comes first. In that word, bit 15 = 0 means a write, bits 14:13 = 01 means two data bytes, and bits 12:0 hold the zero-extended `addr_i`. The word is followed by `wdata_i`, with bit 15 sent first.
- R4: `sclk_o` rests low. For each bit it is low for H system cycles and then high for H cycles. H is `div_i` latched at acceptance, and a value of 0 counts as 1. The first bit appears on `sdo_o` in the cycle the chip select falls. Later bits change only when `sclk_o` falls.
- R5: When `auto_commit_i` is high at acceptance, the data frame is followed by a 24-bit commit frame. Its instruction word has bit 15 = 0, bits 14:13 = 00 (one byte) and address 0x0FF, and it is followed by the byte 0x01.
- R6: After every frame, all chip selects stay high and `sclk_o` stays low for 4H cycles, which is two serial-clock periods. Only then does the next frame start or `idle_o` rise.
- R7: A strobe while `idle_o` is low has no effect on the transfer in progress. It sets `overrun_o`, which stays high until reset.
- R8: During and right after reset, `idle_o` = 1, all chip selects are high, and `sclk_o`, `sdo_o` and `overrun_o` are 0.
- R9: `sdo_o` is 0 whenever no frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dev_sel_i | input | 8 | Target device number |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Register write data |
| auto_commit_i | input | 1 | Append a commit frame after the data frame |
| div_i | input | 8 | Serial-clock half period in system cycles (0 acts as 1) |
| wr_i | input | 1 | One-cycle start strobe |
| idle_o | output | 1 | Ready for a new write |
| overrun_o | output | 1 | Sticky flag: strobe arrived while busy |
| sclk_o | output | 1 | Serial clock, rests low |
| sdo_o | output | 1 | Serial data, MSB first |
| cs_no | output | 4 | Active-low chip selects, one per device |

## Verification
Some properties are checked by assertions on every cycle:
- at most one chip select is low, and it does not change within a frame;
- idle implies a quiet bus;
- data moves only on falling serial-clock edges;
- the minimum high time of the chip selects between frames;
- the overrun flag sets when a strobe arrives while busy, and then stays set.

Other behaviour shows only in the bench's scenarios, where a queue-based reference model predicts every output bit per cycle and compares it. That covers:
- the exact bit content of the data and commit frames;
- the divider value and its zero case;
- the out-of-range device number;
- a back-to-back start on the first idle cycle;
- the fact that a strobe during a transfer leaves the transfer unchanged.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } eng_state_e;

  localparam int unsigned INSTR_W   = 16;
  localparam int unsigned RADDR_W   = 13;
  localparam logic [7:0]  UPD_ADDR  = 8'hFF;
  localparam logic [7:0]  UPD_VALUE = 8'h01;

  // write flag (0), byte-count code, register address
  function automatic logic [INSTR_W-1:0] instr_word(input logic [1:0] len_code,
                                                    input logic [RADDR_W-1:0] reg_addr);
    return {1'b0, len_code, reg_addr};
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int unsigned FRAME_W = 32,
  localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   left_q;

  assign bit_o  = sr_q[FRAME_W-1];
  assign last_o = (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= frame_i;
      left_q <= len_i;
    end else if (shift_i) begin
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      left_q <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned SEL_W   = 8
) (
  input  logic               en_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [NUM_DEV-1:0] cs_no
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (sel_i == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_wr_engine.sv
module spi_wr_engine
  import spi_wr_pkg::*;
#(
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned SEL_W    = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned GAP_SCLK = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   dev_sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               auto_commit_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               wr_i,
  output logic               idle_o,
  output logic               overrun_o,
  output logic               sclk_o,
  output logic               sdo_o,
  output logic [NUM_DEV-1:0] cs_no
);
  localparam int unsigned FRAME_W   = INSTR_W + DATA_W;
  localparam int unsigned COMMIT_W  = INSTR_W + 8;
  localparam int unsigned CNT_W     = $clog2(FRAME_W + 1);
  localparam int unsigned GAP_TICKS = 2 * GAP_SCLK;
  localparam int unsigned GAP_W     = $clog2(GAP_TICKS + 1);
  localparam logic [1:0]  DATA_LEN  = 2'(DATA_W / 8 - 1);

  eng_state_e       state_q, state_d;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] half_q;
  logic             sclk_q;
  logic             commit_q;
  logic             ovr_q;
  logic [GAP_W-1:0] gap_q;

  logic               tick, accept, gap_done, load, shift, bit_out, last_bit;
  logic [FRAME_W-1:0] data_frame, commit_frame, frame_mux;
  logic [CNT_W-1:0]   len_mux;

  assign accept   = (state_q == ST_IDLE) && wr_i;
  assign gap_done = (state_q == ST_GAP) && tick && (gap_q == GAP_W'(GAP_TICKS - 1));
  assign load     = accept || (gap_done && commit_q);
  assign shift    = (state_q == ST_SHIFT) && tick && sclk_q && !last_bit;

  assign data_frame   = {instr_word(DATA_LEN, RADDR_W'(addr_i)), wdata_i};
  assign commit_frame = {instr_word(2'b00, RADDR_W'(UPD_ADDR)), UPD_VALUE,
                         {(FRAME_W - COMMIT_W){1'b0}}};
  assign frame_mux    = accept ? data_frame : commit_frame;
  assign len_mux      = accept ? CNT_W'(FRAME_W) : CNT_W'(COMMIT_W);

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .half_i (half_q),
    .tick_o (tick)
  );

  spi_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame_mux),
    .len_i   (len_mux),
    .shift_i (shift),
    .bit_o   (bit_out),
    .last_o  (last_bit)
  );

  spi_cs_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_cs (
    .en_i  (state_q == ST_SHIFT),
    .sel_i (sel_q),
    .cs_no (cs_no)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SHIFT;
      ST_SHIFT: if (tick && sclk_q && last_bit) state_d = ST_GAP;
      ST_GAP:   if (gap_done) state_d = commit_q ? ST_SHIFT : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      half_q   <= DIV_W'(1);
      sclk_q   <= 1'b0;
      commit_q <= 1'b0;
      ovr_q    <= 1'b0;
      gap_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sel_q  <= dev_sel_i;
        half_q <= (div_i == '0) ? DIV_W'(1) : div_i;
      end
      if (accept)                             commit_q <= auto_commit_i;
      else if (load)                          commit_q <= 1'b0;
      if (load)                               sclk_q <= 1'b0;
      else if (state_q == ST_SHIFT && tick)   sclk_q <= !sclk_q;
      if (state_q != ST_GAP)                  gap_q <= '0;
      else if (tick)                          gap_q <= gap_q + GAP_W'(1);
      if (wr_i && state_q != ST_IDLE)         ovr_q <= 1'b1;
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign overrun_o = ovr_q;
  assign sclk_o    = sclk_q;
  assign sdo_o     = (state_q == ST_SHIFT) && bit_out;
endmodule

// File: rtl/spi_wr_engine_chk.sv
module spi_wr_engine_chk #(
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned GAP_SCLK = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               idle_o,
  input logic               overrun_o,
  input logic               sclk_o,
  input logic               sdo_o,
  input logic [NUM_DEV-1:0] cs_no
);
  logic       quiet;
  logic [4:0] hi_cnt;
  logic       seen_frame;

  assign quiet = &cs_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (!quiet)            hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 5'd1;
      if (!quiet)            seen_frame <= 1'b1;
    end
  end

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (quiet && !sclk_o));

  // R2
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R2
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quiet && !$past(quiet)) |-> $stable(cs_no));

  // R4
  sdo_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quiet && !$past(quiet) && !$fell(sclk_o)) |-> $stable(sdo_o));

  // R6
  gap_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(quiet) && seen_frame) |-> (hi_cnt >= 5'(2 * GAP_SCLK)));

  // R7
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !idle_o) |=> overrun_o);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R9
  sdo_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && idle_o) |-> !sdo_o);
endmodule

bind spi_wr_engine spi_wr_engine_chk #(.NUM_DEV(NUM_DEV), .GAP_SCLK(GAP_SCLK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .idle_o    (idle_o),
  .overrun_o (overrun_o),
  .sclk_o    (sclk_o),
  .sdo_o     (sdo_o),
  .cs_no     (cs_no)
);

// File: tb/spi_wr_engine_test.sv
module spi_wr_engine_test;
  localparam int CLK_PERIOD = 25;
  localparam int NUM_DEV    = 4;

  typedef struct {
    logic [NUM_DEV-1:0] cs;
    logic               sclk;
    logic               sdo;
    int                 kind;  // 0 data frame, 1 commit frame, 2 gap
  } exp_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [7:0]         dev_sel = '0;
  logic [7:0]         addr = '0;
  logic [15:0]        wdata = '0;
  logic               auto_commit = 1'b0;
  logic [7:0]         div = 8'd1;
  logic               wr = 1'b0;
  logic               idle, ovr, sclk, sdo;
  logic [NUM_DEV-1:0] cs_n;

  exp_t q[$];
  logic m_ovr = 1'b0;
  int   checks = 0;
  int   fails  = 0;
  int   cycles = 0;

  spi_wr_engine uut (
    .clk_i (clk), .rst_ni (rst_n), .dev_sel_i (dev_sel), .addr_i (addr),
    .wdata_i (wdata), .auto_commit_i (auto_commit), .div_i (div), .wr_i (wr),
    .idle_o (idle), .overrun_o (ovr), .sclk_o (sclk), .sdo_o (sdo), .cs_no (cs_n)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  function automatic void push_frame(logic [31:0] bits, int n, int dv, int h, int kind);
    logic [NUM_DEV-1:0] csv;
    csv = (dv < NUM_DEV) ? ~(NUM_DEV'(1) << dv) : '1;
    for (int i = n - 1; i >= 0; i--) begin
      for (int k = 0; k < h; k++) q.push_back('{csv, 1'b0, bits[i], kind});
      for (int k = 0; k < h; k++) q.push_back('{csv, 1'b1, bits[i], kind});
    end
    for (int k = 0; k < 4 * h; k++) q.push_back('{'1, 1'b0, 1'b0, 2});
  endfunction

  // reference model: advances at each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit was_idle = (q.size() == 0);
      if (!was_idle) void'(q.pop_front());
      if (wr) begin
        if (was_idle) begin
          automatic int h = (div == 0) ? 1 : int'(div);
          push_frame({1'b0, 2'b01, 5'b0, addr, wdata}, 32, int'(dev_sel), h, 0);
          if (auto_commit) push_frame({8'h0, 1'b0, 2'b00, 13'h0FF, 8'h01}, 24, int'(dev_sel), h, 1);
        end else begin
          m_ovr = 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic exp_t e = (q.size() != 0) ? q[0] : '{'1, 1'b0, 1'b0, 2};
      automatic string tag = (e.kind == 1) ? "R5" : (e.kind == 2 ? "R6" : "R3");
      chk("R1", "idle", 8'(idle), 8'(q.size() == 0));
      chk((e.kind == 2) ? "R6" : "R2", "cs_n", 8'(cs_n), 8'(e.cs));
      chk((e.kind == 2) ? "R6" : "R4", "sclk", 8'(sclk), 8'(e.sclk));
      chk((q.size() == 0) ? "R9" : tag, "sdo", 8'(sdo), 8'(e.sdo));
      chk("R7", "overrun", 8'(ovr), 8'(m_ovr));
    end
  end

  task automatic send(input logic [7:0] d, input logic [7:0] a, input logic [15:0] v,
                      input logic ac, input logic [7:0] dv);
    while (!idle) @(negedge clk);
    dev_sel = d; addr = a; wdata = v; auto_commit = ac; div = dv; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!idle) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset values
    chk("R8", "idle", 8'(idle), 8'd1);
    chk("R8", "cs_n", 8'(cs_n), 8'(4'hF));
    chk("R8", "sclk", 8'(sclk), 8'd0);
    chk("R8", "sdo", 8'(sdo), 8'd0);
    chk("R8", "overrun", 8'(ovr), 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "idle after reset", 8'(idle), 8'd1);

    send(8'd0, 8'h14, 16'hA55A, 1'b0, 8'd1);   // R3 basic frame, fastest clock
    wait_idle();
    send(8'd2, 8'h3C, 16'h8001, 1'b1, 8'd3);   // R5 commit frame, R4 H=3
    wait_idle();
    send(8'd3, 8'hFF, 16'hFFFF, 1'b0, 8'd0);   // R4 divider 0 acts as 1
    wait_idle();
    send(8'd9, 8'h01, 16'h1234, 1'b1, 8'd2);   // R2 out-of-range device
    wait_idle();
    // R1 back-to-back: start on first idle cycle
    send(8'd1, 8'h55, 16'h00FF, 1'b0, 8'd1);
    send(8'd1, 8'hAA, 16'hFF00, 1'b1, 8'd1);
    // R7 strobe while busy: ignored, flag set
    repeat (5) @(negedge clk);
    dev_sel = 8'd0; addr = 8'h77; wdata = 16'hDEAD; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    wait_idle();
    send(8'd2, 8'h20, 16'h0F0F, 1'b0, 8'd2);   // R7 flag stays set
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R7", "overrun sticky", 8'(ovr), 8'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule